// File: doc/BRIEF.md
# Dual-Set Baud Clock Selector

This block turns one reference clock enable into four sample-clock tick enables for a two-channel UART, one for each of receive A, transmit A, receive B and transmit B. Each path has its own 4-bit select code. One global bit picks which of two fixed baud tables the rate codes draw from. The remaining codes route either a shared timer pulse or a per-path external clock pin to the path. The pin can act as a 16x sample clock or as a 1x bit clock.

Every table rate is produced by an integer divider on the reference enable. The divider is the reference frequency over sixteen times the rate, rounded to the nearest integer. The default reference is 3.6864 MHz, and the rates scale linearly with it. External pins are synchronised and edge-detected before use. The shift logic and the timer that feed and consume these ticks live elsewhere.

Top module: `baud_clk_sel`

## Requirements
- R1: While reset is held, and until a source produces a tick, every bit of `tick_o` and `x1_o` is 0.
- R2: With `alt_set_i` = 0, codes 0 to 12 select, in code order, 50, 110, 134.5, 200, 300, 600, 1200, 1050, 2400, 4800, 7200, 9600 and 38400 baud. The path ticks once every D reference enables, where D = round(REF_HZ / (16 × rate)); for example D = 6 at 38400 baud.
- R3: With `alt_set_i` = 1, codes 0 to 12 select, in code order, 75, 110, 134.5, 150, 300, 600, 1200, 2000, 2400, 4800, 1800, 9600 and 19200 baud, with the same divider rule (D = 12 at 19200 baud).
- R4: A rate divider advances only in cycles where `ref_en_i` is 1. With enables in every other cycle the tick period doubles, and with no enables no rate tick appears.
- R5: When a path's code or `alt_set_i` changes, that path's divider restarts from zero. Its first tick appears exactly D+1 clock edges after the edge that samples the new setting, and no tick appears before it.
- R6: Code 13 passes `timer_pulse_i` to the path as a tick one edge after it is sampled, whatever the value of `alt_set_i`.
- R7: Code 14 uses the path's external pin as a 16x clock. Each rising edge of the pin yields one single-cycle tick, three edges after the pin is first sampled high. A held level or a falling edge yields nothing.
- R8: Code 15 uses the same pin as a 1x clock with the same edge timing. `x1_o` for a path is 1 one edge after code 15 is sampled, and 0 one edge after any other code is sampled.
- R9: The pin assignment is `ext_clk_i[0]` for receive A, `ext_clk_i[1]` for transmit A, `ext_clk_i[2]` for receive B and `ext_clk_i[3]` for transmit B. A pin has no effect on any other path. Tick and flag bits follow the same index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_en_i | input | 1 | Reference clock enable, one pulse per reference period |
| rx_a_sel_i | input | 4 | Source code for receive A |
| tx_a_sel_i | input | 4 | Source code for transmit A |
| rx_b_sel_i | input | 4 | Source code for receive B |
| tx_b_sel_i | input | 4 | Source code for transmit B |
| alt_set_i | input | 1 | Baud table choice: 0 first table, 1 second table |
| timer_pulse_i | input | 1 | Single-cycle pulse from the counter/timer |
| ext_clk_i | input | 4 | External clock pins, one per path (see R9) |
| tick_o | output | 4 | Single-cycle tick enable per path |
| x1_o | output | 4 | Per path: 1 when the tick is a 1x bit clock, 0 when it is a 16x clock |

## Verification
The bench drives inputs on the falling edge and samples at the next falling edges. Each result is checked at the falling edge where it is due:
- A new rate setting gives its first tick D+1 edges after it is sampled and the next one D edges later.
- A timer pulse gives its tick after one edge.
- A pin rise gives its tick after the third edge.
- The 1x flag settles after one edge.

The bench checks each window cycle by cycle. It requires zero ticks in every other cycle, which also exposes runt or duplicate ticks. The expected divisors come from the rate lists computed in floating point.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;

  localparam int SEL_W = 4;
  localparam logic [SEL_W-1:0] CODE_TIMER = 4'hD;
  localparam logic [SEL_W-1:0] CODE_PIN16 = 4'hE;
  localparam logic [SEL_W-1:0] CODE_PIN1  = 4'hF;

  // Baud rate in tenths for a table code; 0 means "not a divider code".
  function automatic int unsigned rate_x10(bit alt, int unsigned code);
    case (code)
      0:       return alt ? 750    : 500;
      1:       return 1100;
      2:       return 1345;
      3:       return alt ? 1500   : 2000;
      4:       return 3000;
      5:       return 6000;
      6:       return 12000;
      7:       return alt ? 20000  : 10500;
      8:       return 24000;
      9:       return 48000;
      10:      return alt ? 18000  : 72000;
      11:      return 96000;
      12:      return alt ? 192000 : 384000;
      default: return 0;
    endcase
  endfunction

  // Reference enables per 16x tick, rounded to nearest.
  function automatic int unsigned rate_div(longint unsigned ref_hz, bit alt,
                                           int unsigned code);
    longint unsigned r;
    r = longint'(rate_x10(alt, code));
    if (r == 0) return 0;
    return int'((ref_hz * 10 + 8 * r) / (16 * r));
  endfunction

  function automatic int unsigned max_rate_div(longint unsigned ref_hz);
    int unsigned m;
    m = 1;
    for (int a = 0; a < 2; a++) begin
      for (int c = 0; c < (1 << SEL_W); c++) begin
        if (rate_div(ref_hz, a[0], c) > m) m = rate_div(ref_hz, a[0], c);
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/baud_rate_div.sv
module baud_rate_div
  import baud_sel_pkg::*;
#(
  parameter longint unsigned REF_HZ = 3686400,
  parameter int              CNT_W  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en_i,
  input  logic             alt_i,
  input  logic [SEL_W-1:0] code_i,
  output logic             tick_o
);

  localparam int TAB_N = 2 * (1 << SEL_W);

  logic [CNT_W-1:0] div_tab [TAB_N];
  logic [SEL_W:0]   cfg_d, cfg_q;
  logic [CNT_W-1:0] cnt_d, cnt_q, div_cur;
  logic             cfg_new, active, wrap;

  for (genvar g = 0; g < TAB_N; g++) begin : g_tab
    localparam int unsigned D = rate_div(REF_HZ, (g >= (1 << SEL_W)), g % (1 << SEL_W));
    assign div_tab[g] = CNT_W'(D);
  end

  assign cfg_d   = {alt_i, code_i};
  assign div_cur = div_tab[cfg_d];
  assign cfg_new = (cfg_d != cfg_q);
  assign active  = (div_cur != '0);
  assign wrap    = active && !cfg_new && ref_en_i && (cnt_q == div_cur - CNT_W'(1));
  assign tick_o  = wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (cfg_new || !active) begin
      cnt_d = '0;
    end else if (ref_en_i) begin
      cnt_d = wrap ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_new && active) |-> (cnt_q < div_cur)); // R2
  AST_WRAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0)); // R3
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_new |=> !tick_o); // R5

endmodule

// File: rtl/baud_pin_edge.sv
module baud_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R7

endmodule

// File: rtl/baud_src_mux.sv
module baud_src_mux
  import baud_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code_i,
  input  logic             div_tick_i,
  input  logic             timer_i,
  input  logic             pin_rise_i,
  output logic             tick_o,
  output logic             x1_o
);

  logic tick_d, x1_d;

  always_comb begin
    case (code_i)
      CODE_TIMER:           tick_d = timer_i;
      CODE_PIN16, CODE_PIN1: tick_d = pin_rise_i;
      default:              tick_d = div_tick_i;
    endcase
    x1_d = (code_i == CODE_PIN1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_o <= 1'b0;
      x1_o   <= 1'b0;
    end else begin
      tick_o <= tick_d;
      x1_o   <= x1_d;
    end
  end

  AST_TIMER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == CODE_TIMER && timer_i) |=> tick_o); // R6
  AST_X1_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == CODE_PIN1) |=> x1_o); // R8
  AST_X1_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i != CODE_PIN1) |=> !x1_o); // R8

endmodule

// File: rtl/baud_clk_sel.sv
module baud_clk_sel
  import baud_sel_pkg::*;
#(
  parameter longint unsigned REF_HZ = 3686400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en_i,
  input  logic [SEL_W-1:0] rx_a_sel_i,
  input  logic [SEL_W-1:0] tx_a_sel_i,
  input  logic [SEL_W-1:0] rx_b_sel_i,
  input  logic [SEL_W-1:0] tx_b_sel_i,
  input  logic             alt_set_i,
  input  logic             timer_pulse_i,
  input  logic [3:0]       ext_clk_i,
  output logic [3:0]       tick_o,
  output logic [3:0]       x1_o
);

  localparam int N_CHAN = 2;
  localparam int PATHS  = 2 * N_CHAN;
  localparam int CNT_W  = $clog2(max_rate_div(REF_HZ) + 1);

  logic             rst_meta_q, rst_sync_q;
  logic [SEL_W-1:0] sel [PATHS];
  logic [PATHS-1:0] div_tick, pin_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign sel[0] = rx_a_sel_i;
  assign sel[1] = tx_a_sel_i;
  assign sel[2] = rx_b_sel_i;
  assign sel[3] = tx_b_sel_i;

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    baud_rate_div #(.REF_HZ(REF_HZ), .CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_sync_q),
      .ref_en_i (ref_en_i),
      .alt_i    (alt_set_i),
      .code_i   (sel[p]),
      .tick_o   (div_tick[p])
    );

    baud_pin_edge u_pin (
      .clk    (clk),
      .rst_n  (rst_sync_q),
      .pin_i  (ext_clk_i[p]),
      .rise_o (pin_rise[p])
    );

    baud_src_mux u_mux (
      .clk        (clk),
      .rst_n      (rst_sync_q),
      .code_i     (sel[p]),
      .div_tick_i (div_tick[p]),
      .timer_i    (timer_pulse_i),
      .pin_rise_i (pin_rise[p]),
      .tick_o     (tick_o[p]),
      .x1_o       (x1_o[p])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |=> (tick_o == '0 && x1_o == '0)); // R1
  AST_REF_GATES: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!ref_en_i && sel[0] < CODE_TIMER) |=> !tick_o[0]); // R4

endmodule

// File: tb/baud_clk_sel_tb_top.sv
module baud_clk_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b1;
  logic [3:0] sel_ra = 4'd0, sel_ta = 4'd0, sel_rb = 4'd0, sel_tb = 4'd0;
  logic       alt = 1'b0;
  logic       timer = 1'b0;
  logic [3:0] ext = 4'd0;
  logic [3:0] tick, x1;
  int         n_chk = 0;
  int         n_bad = 0;
  int         ref_mode = 0;

  always #10 clk = ~clk;

  baud_clk_sel dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en_i(ref_en),
    .rx_a_sel_i(sel_ra), .tx_a_sel_i(sel_ta), .rx_b_sel_i(sel_rb), .tx_b_sel_i(sel_tb),
    .alt_set_i(alt), .timer_pulse_i(timer), .ext_clk_i(ext),
    .tick_o(tick), .x1_o(x1)
  );

  always @(negedge clk) begin
    if (ref_mode == 0) ref_en = 1'b1;
    else if (ref_mode == 1) ref_en = ~ref_en;
    else ref_en = 1'b0;
  end

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic real rate_of(bit a, int c);
    real t0 [13] = '{50.0, 110.0, 134.5, 200.0, 300.0, 600.0, 1200.0, 1050.0,
                     2400.0, 4800.0, 7200.0, 9600.0, 38400.0};
    real t1 [13] = '{75.0, 110.0, 134.5, 150.0, 300.0, 600.0, 1200.0, 2000.0,
                     2400.0, 4800.0, 1800.0, 9600.0, 19200.0};
    return a ? t1[c] : t0[c];
  endfunction

  function automatic int exp_div(bit a, int c);
    return $rtoi(3686400.0 / (16.0 * rate_of(a, c)) + 0.5);
  endfunction

  task automatic set_all(bit a, logic [3:0] c);
    @(negedge clk);
    alt = a; sel_ra = c; sel_ta = c; sel_rb = c; sel_tb = c;
  endtask

  // R2 / R3 / R5: first tick at D+1 edges after the change, then period D.
  task automatic run_rate(bit a, int c);
    int d;
    int first [4];
    int second [4];
    d = exp_div(a, c);
    for (int p = 0; p < 4; p++) begin first[p] = -1; second[p] = -1; end
    set_all(a, c[3:0]);
    for (int n = 1; n <= 2 * d + 4; n++) begin
      @(negedge clk);
      for (int p = 0; p < 4; p++) begin
        if (tick[p]) begin
          if (first[p] < 0) first[p] = n;
          else if (second[p] < 0) second[p] = n;
        end
      end
    end
    for (int p = 0; p < 4; p++) begin
      check_eq(a ? "R3/R5 first tick" : "R2/R5 first tick", first[p], d + 1);
      check_eq(a ? "R3 period" : "R2 period", second[p] - first[p], d);
    end
  endtask

  task automatic pin_pulse(int p, logic [3:0] exp_x1);
    @(negedge clk); ext[p] = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      check_eq("R7/R9 pin tick", int'(tick), (n == 3) ? (1 << p) : 0);
    end
    check_eq("R8 x1 flag", int'(x1), int'(exp_x1));
    ext[p] = 1'b0;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      check_eq("R7 falling edge quiet", int'(tick), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 reset tick", int'(tick), 0);
    check_eq("R1 reset x1", int'(x1), 0);
    set_all(1'b0, 4'd13);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1 after release tick", int'(tick), 0);
    check_eq("R1 after release x1", int'(x1), 0);

    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 13; c++)
        run_rate(a[0], c);

    // R4: half-rate enables double the period; no enables, no ticks.
    begin
      int t1 = -1;
      int t2 = -1;
      set_all(1'b0, 4'd12);
      ref_mode = 1;
      for (int n = 1; n <= 60; n++) begin
        @(negedge clk);
        if (tick[0]) begin
          if (t1 < 0) t1 = n; else if (t2 < 0) t2 = n;
        end
      end
      check_eq("R4 half-rate period", t2 - t1, 2 * exp_div(1'b0, 12));
      ref_mode = 2;
      repeat (2) @(negedge clk);
      for (int n = 0; n < 40; n++) begin
        @(negedge clk);
        check_eq("R4 no enable no tick", int'(tick), 0);
      end
      ref_mode = 0;
    end

    // R6: timer routing under both table choices.
    for (int a = 0; a < 2; a++) begin
      set_all(a[0], 4'd13);
      repeat (3) @(negedge clk);
      check_eq("R6 idle", int'(tick), 0);
      timer = 1'b1;
      @(negedge clk);
      timer = 1'b0;
      check_eq("R6 timer tick", int'(tick), 15);
      @(negedge clk);
      check_eq("R6 single cycle", int'(tick), 0);
    end

    // R7 / R9: 16x pin mode, one pin at a time.
    set_all(1'b0, 4'd14);
    repeat (4) @(negedge clk);
    for (int p = 0; p < 4; p++) pin_pulse(p, 4'h0);

    // R8: 1x pin mode.
    set_all(1'b1, 4'd15);
    repeat (4) @(negedge clk);
    for (int p = 0; p < 4; p++) pin_pulse(p, 4'hF);

    // R8 / R9: mixed codes per path.
    @(negedge clk);
    sel_ra = 4'd15; sel_ta = 4'd14; sel_rb = 4'd13; sel_tb = 4'd5;
    repeat (2) @(negedge clk);
    check_eq("R8 mixed x1", int'(x1), 1);
    ext = 4'b1111;
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      check_eq("R9 mixed pin tick", int'(tick & 4'b0111), (n == 3) ? 3 : 0);
    end
    ext = 4'b0000;

    summary();
  end

endmodule